// File: doc/BRIEF.md
# Configurable PRBS Generator and Checker

This block produces a parallel pseudo-random test stream on its transmit side and checks a received stream against its own copy of the same sequence on its receive side. It is used for link bring-up and bit-error-rate measurement. A host loads a pattern and a starting state into either side with one command. It then reads the accumulated bit-error count and the lock, error and halt flags.

Both sides share one 16-bit command word. Its low byte picks one of seven LFSR polynomials or a fixed 32-bit user word, and it holds the receive-only flags: reseed-on-error, all-zero escape and stop-on-error. Bits 8 and 9 direct the command to the transmit side, the receive side, or both. A low byte of all ones turns the addressed sides off instead of loading them. Each word carries W consecutive sequence bits. The first bit in time sits in bit W-1.

Top module: `prbs_unit`

## Requirements
- R1: After reset both sides are off, and tx_valid, tx_data, rx_err, rx_lock, rx_halted and rx_err_cnt are all zero.
- R2: A command is taken when cmd_valid is high and cmd_word[15:10] is zero; otherwise it has no effect. Bits [2:0] select the pattern, bit 4 is reseed-on-error, bit 5 is the all-zero escape and bit 7 is stop-on-error. Bit 8 addresses the TX side and bit 9 the RX side.
- R3: Pattern codes 0..6 select x^7+x^6+1, x^9+x^5+1, x^11+x^9+1, x^15+x^14+1, x^23+x^18+1, x^31+x^28+1 and x^13+x^12+x^2+x+1. A load puts seed into the n-bit state and drives tx_valid low for one cycle. After that, each cycle outputs the next W feedback bits, first bit in bit W-1, with the state shifting left and the feedback bit entering bit 0.
- R4: Pattern code 7 repeats the 32-bit user_pat captured at load, starting at its bit 31. Later changes on user_pat have no effect until the next load.
- R5: With the all-zero escape set, a zero LFSR state is replaced by all ones before it is stepped. Without it, a zero state yields all-zero words.
- R6: Each valid received word adds the popcount of (rx_data XOR expected) to rx_err_cnt. rx_err is high for one cycle when that popcount is non-zero.
- R7: rx_err_cnt saturates at all ones.
- R8: rx_lock rises after LOCK_WORDS consecutive error-free words and falls on the first word with an error.
- R9: With reseed-on-error set, a mismatching word reloads the checker state from the low bits of rx_data, so the checker follows a shifted sequence from the next word. Without it, the checker keeps its own phase.
- R10: With stop-on-error set, the first errored word sets rx_halted. Further words then neither count nor raise rx_err until the RX side is loaded again.
- R11: err_clr sets rx_err_cnt to zero on the next edge and takes priority over counting.
- R12: Command 0x01FF turns TX off, 0x02FF turns RX off and 0x03FF turns both off. An off TX holds tx_valid and tx_data at zero. An off RX ignores rx_valid and holds rx_lock, rx_err and rx_halted low.
- R13: A load addressed to one side leaves the other side's pattern and state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 16 | Pattern, flags, side select or disable code |
| seed | input | 32 | Starting LFSR state taken at load |
| user_pat | input | 32 | User pattern taken at load |
| err_clr | input | 1 | Clear the error counter |
| tx_data | output | W | Generated word |
| tx_valid | output | 1 | tx_data holds a sequence word |
| tx_on | output | 1 | TX side enabled |
| rx_valid | input | 1 | rx_data is to be checked |
| rx_data | input | W | Received word |
| rx_on | output | 1 | RX side enabled |
| rx_err | output | 1 | Last checked word had errors |
| rx_lock | output | 1 | Error-free run reached LOCK_WORDS |
| rx_halted | output | 1 | Checker stopped after an error |
| rx_err_cnt | output | CNT_W | Saturating bit-error count |

## Verification
The generator runs through all seven polynomials from distinct seeds and through the user word. This separates tap positions, bit order and the seed-to-state mapping. The checker receives a clean stream and streams with 3-, 8- and 32-bit flips. These tell a popcount from a per-word count and show where the lock threshold falls. A stream taken from a different phase of the sequence tells reseed apart from free-running. Zero seeds, a full inversion run to saturation on a narrowed counter, and the three disable codes cover the boundary cases.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  typedef enum logic [2:0] {
    PAT_7    = 3'd0,
    PAT_9    = 3'd1,
    PAT_11   = 3'd2,
    PAT_15   = 3'd3,
    PAT_23   = 3'd4,
    PAT_31   = 3'd5,
    PAT_13   = 3'd6,
    PAT_USER = 3'd7
  } prbs_pat_e;

  typedef struct packed {
    prbs_pat_e pat;
    logic      reseed;
    logic      autoseed;
    logic      halt_on_err;
  } prbs_cfg_t;

  // Feedback taps: bit (d-1) for each term x^d of the polynomial.
  function automatic logic [31:0] tap_mask(input prbs_pat_e p);
    case (p)
      PAT_7:   return 32'h0000_0060;
      PAT_9:   return 32'h0000_0110;
      PAT_11:  return 32'h0000_0500;
      PAT_15:  return 32'h0000_6000;
      PAT_23:  return 32'h0042_0000;
      PAT_31:  return 32'h4800_0000;
      PAT_13:  return 32'h0000_1803;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] len_mask(input prbs_pat_e p);
    case (p)
      PAT_7:   return 32'h0000_007F;
      PAT_9:   return 32'h0000_01FF;
      PAT_11:  return 32'h0000_07FF;
      PAT_15:  return 32'h0000_7FFF;
      PAT_23:  return 32'h007F_FFFF;
      PAT_31:  return 32'h7FFF_FFFF;
      PAT_13:  return 32'h0000_1FFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/prbs_step.sv
module prbs_step
  import prbs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [31:0] state_i,
  input  prbs_pat_e   pat_i,
  input  logic        autoseed_i,
  output logic [W-1:0] word_o,
  output logic [31:0] state_o
);

  logic [31:0] s;
  logic [31:0] msk;
  logic [31:0] tap;
  logic        fb;

  // Unrolled W-step advance; the first bit in time lands in word_o[W-1].
  always_comb begin
    msk = len_mask(pat_i);
    tap = tap_mask(pat_i);
    s   = state_i;
    fb  = 1'b0;
    if (pat_i != PAT_USER) begin
      s = s & msk;
      if (autoseed_i && (s == 32'd0)) s = msk;
    end
    word_o = '0;
    for (int i = 0; i < W; i++) begin
      if (pat_i == PAT_USER) begin
        fb = s[31];
        s  = {s[30:0], s[31]};
      end else begin
        fb = ^(s & tap);
        s  = ((s << 1) | {31'd0, fb}) & msk;
      end
      word_o[W-1-i] = fb;
    end
    state_o = s;
  end

endmodule

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
  import prbs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         off_i,
  input  prbs_pat_e    pat_i,
  input  logic         autoseed_i,
  input  logic [31:0]  seed_i,
  input  logic [31:0]  user_i,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         on_o
);

  prbs_pat_e    pat_q;
  logic         aseed_q;
  logic [31:0]  state_q;
  logic [W-1:0] word_n;
  logic [31:0]  state_n;

  prbs_step #(.W(W)) u_step (
    .state_i   (state_q),
    .pat_i     (pat_q),
    .autoseed_i(aseed_q),
    .word_o    (word_n),
    .state_o   (state_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      on_o    <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      state_q <= '0;
      pat_q   <= PAT_7;
      aseed_q <= 1'b0;
    end else if (load_i) begin
      on_o    <= 1'b1;
      valid_o <= 1'b0;
      data_o  <= '0;
      pat_q   <= pat_i;
      aseed_q <= autoseed_i;
      state_q <= (pat_i == PAT_USER) ? user_i : (seed_i & len_mask(pat_i));
    end else if (off_i) begin
      on_o    <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (on_o) begin
      valid_o <= 1'b1;
      data_o  <= word_n;
      state_q <= state_n;
    end
  end

endmodule

// File: rtl/prbs_rx_chk.sv
module prbs_rx_chk
  import prbs_pkg::*;
#(
  parameter int W          = 32,
  parameter int CNT_W      = 32,
  parameter int LOCK_WORDS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             off_i,
  input  prbs_cfg_t        cfg_i,
  input  logic [31:0]      seed_i,
  input  logic [31:0]      user_i,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic [W-1:0]     data_i,
  output logic             err_o,
  output logic             lock_o,
  output logic             halted_o,
  output logic             on_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int NW = $clog2(W + 1);
  localparam int LW = $clog2(LOCK_WORDS + 1);
  localparam int RS = (W < 32) ? W : 32;

  prbs_cfg_t      cfg_q;
  logic [31:0]    state_q;
  logic [LW-1:0]  run_q;
  logic [W-1:0]   exp_w;
  logic [31:0]    state_n;
  logic [31:0]    reseed_st;
  logic [NW-1:0]  nerr;
  logic [CNT_W:0] sum;
  logic [LW:0]    run_inc;
  logic           check;

  prbs_step #(.W(W)) u_step (
    .state_i   (state_q),
    .pat_i     (cfg_q.pat),
    .autoseed_i(cfg_q.autoseed),
    .word_o    (exp_w),
    .state_o   (state_n)
  );

  always_comb begin
    logic [W-1:0] diff;
    diff = data_i ^ exp_w;
    nerr = '0;
    for (int i = 0; i < W; i++) nerr = nerr + NW'(diff[i]);
    reseed_st = '0;
    for (int i = 0; i < RS; i++) reseed_st[i] = data_i[i];
    reseed_st = reseed_st & len_mask(cfg_q.pat);
    sum     = {1'b0, cnt_o} + (CNT_W + 1)'(nerr);
    run_inc = {1'b0, run_q} + (LW + 1)'(1);
    check   = on_o && !halted_o && valid_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      state_q  <= '0;
      run_q    <= '0;
      on_o     <= 1'b0;
      err_o    <= 1'b0;
      lock_o   <= 1'b0;
      halted_o <= 1'b0;
      cnt_o    <= '0;
    end else begin
      err_o <= 1'b0;
      if (load_i) begin
        on_o     <= 1'b1;
        cfg_q    <= cfg_i;
        state_q  <= (cfg_i.pat == PAT_USER) ? user_i : (seed_i & len_mask(cfg_i.pat));
        run_q    <= '0;
        lock_o   <= 1'b0;
        halted_o <= 1'b0;
      end else if (off_i) begin
        on_o     <= 1'b0;
        run_q    <= '0;
        lock_o   <= 1'b0;
        halted_o <= 1'b0;
      end else if (check) begin
        if (nerr != '0) begin
          err_o    <= 1'b1;
          lock_o   <= 1'b0;
          run_q    <= '0;
          halted_o <= cfg_q.halt_on_err;
          state_q  <= (cfg_q.reseed && cfg_q.pat != PAT_USER) ? reseed_st : state_n;
        end else begin
          state_q <= state_n;
          if (run_inc >= (LW + 1)'(LOCK_WORDS)) begin
            lock_o <= 1'b1;
            run_q  <= LW'(LOCK_WORDS);
          end else begin
            run_q  <= run_inc[LW-1:0];
          end
        end
      end
      if (clr_i) begin
        cnt_o <= '0;
      end else if (check) begin
        cnt_o <= sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/prbs_unit.sv
module prbs_unit
  import prbs_pkg::*;
#(
  parameter int W          = 32,
  parameter int CNT_W      = 32,
  parameter int LOCK_WORDS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [15:0]      cmd_word,
  input  logic [31:0]      seed,
  input  logic [31:0]      user_pat,
  input  logic             err_clr,
  output logic [W-1:0]     tx_data,
  output logic             tx_valid,
  output logic             tx_on,
  input  logic             rx_valid,
  input  logic [W-1:0]     rx_data,
  output logic             rx_on,
  output logic             rx_err,
  output logic             rx_lock,
  output logic             rx_halted,
  output logic [CNT_W-1:0] rx_err_cnt
);

  logic      cmd_ok;
  logic      is_off;
  logic      tx_ld;
  logic      tx_dis;
  logic      rx_ld;
  logic      rx_dis;
  prbs_cfg_t cfg;

  always_comb begin
    cmd_ok          = cmd_valid && (cmd_word[15:10] == 6'd0);
    is_off          = (cmd_word[7:0] == 8'hFF);
    tx_ld           = cmd_ok && cmd_word[8] && !is_off;
    tx_dis          = cmd_ok && cmd_word[8] && is_off;
    rx_ld           = cmd_ok && cmd_word[9] && !is_off;
    rx_dis          = cmd_ok && cmd_word[9] && is_off;
    cfg.pat         = prbs_pat_e'(cmd_word[2:0]);
    cfg.reseed      = cmd_word[4];
    cfg.autoseed    = cmd_word[5];
    cfg.halt_on_err = cmd_word[7];
  end

  prbs_tx_gen #(.W(W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tx_ld),
    .off_i     (tx_dis),
    .pat_i     (cfg.pat),
    .autoseed_i(cfg.autoseed),
    .seed_i    (seed),
    .user_i    (user_pat),
    .data_o    (tx_data),
    .valid_o   (tx_valid),
    .on_o      (tx_on)
  );

  prbs_rx_chk #(.W(W), .CNT_W(CNT_W), .LOCK_WORDS(LOCK_WORDS)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .load_i  (rx_ld),
    .off_i   (rx_dis),
    .cfg_i   (cfg),
    .seed_i  (seed),
    .user_i  (user_pat),
    .clr_i   (err_clr),
    .valid_i (rx_valid),
    .data_i  (rx_data),
    .err_o   (rx_err),
    .lock_o  (rx_lock),
    .halted_o(rx_halted),
    .on_o    (rx_on),
    .cnt_o   (rx_err_cnt)
  );

endmodule

// File: rtl/prbs_unit_sva.sv
module prbs_unit_sva #(
  parameter int W     = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [15:0]      cmd_word,
  input logic             err_clr,
  input logic [W-1:0]     tx_data,
  input logic             tx_valid,
  input logic             tx_on,
  input logic             rx_on,
  input logic             rx_err,
  input logic             rx_lock,
  input logic             rx_halted,
  input logic [CNT_W-1:0] rx_err_cnt
);

  logic rx_cmd;
  assign rx_cmd = cmd_valid && cmd_word[9] && (cmd_word[15:10] == 6'd0);

  // R6: the count never falls unless a clear was requested
  a_r6_cnt_grows: assert property (@(posedge clk) disable iff (rst)
    !err_clr |=> rx_err_cnt >= $past(rx_err_cnt));

  // R6/R7: an error flag implies the count moved, or it sits at saturation
  a_r7_err_moves_cnt: assert property (@(posedge clk) disable iff (rst)
    (rx_err && !$past(err_clr)) |-> (rx_err_cnt != $past(rx_err_cnt)) || (&rx_err_cnt));

  // R8: an errored word never coexists with lock
  a_r8_lock_drop: assert property (@(posedge clk) disable iff (rst)
    rx_err |-> !rx_lock);

  // R10: a halted checker holds its count and stays halted
  a_r10_halt_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_halted && !err_clr && !rx_cmd) |=> ($stable(rx_err_cnt) && rx_halted));

  // R11: clear takes effect on the next edge
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> rx_err_cnt == '0);

  // R12: an off TX side emits nothing
  a_r12_tx_quiet: assert property (@(posedge clk) disable iff (rst)
    !tx_on |-> (!tx_valid && tx_data == '0));

  // R12: an off RX side raises no flags
  a_r12_rx_quiet: assert property (@(posedge clk) disable iff (rst)
    !rx_on |-> (!rx_lock && !rx_err && !rx_halted));

endmodule

bind prbs_unit prbs_unit_sva #(.W(W), .CNT_W(CNT_W)) u_prbs_unit_sva (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_word  (cmd_word),
  .err_clr   (err_clr),
  .tx_data   (tx_data),
  .tx_valid  (tx_valid),
  .tx_on     (tx_on),
  .rx_on     (rx_on),
  .rx_err    (rx_err),
  .rx_lock   (rx_lock),
  .rx_halted (rx_halted),
  .rx_err_cnt(rx_err_cnt)
);

// File: tb/test_prbs_unit.sv
module test_prbs_unit;

  localparam int W     = 32;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic [15:0]      cmd_word = '0;
  logic [31:0]      seed = '0;
  logic [31:0]      user_pat = '0;
  logic             err_clr = 1'b0;
  logic             rx_valid = 1'b0;
  logic [W-1:0]     rx_data = '0;
  logic [W-1:0]     tx_data;
  logic             tx_valid, tx_on, rx_on, rx_err, rx_lock, rx_halted;
  logic [CNT_W-1:0] rx_err_cnt;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  always #4 clk = ~clk;

  prbs_unit #(.W(W), .CNT_W(CNT_W), .LOCK_WORDS(32)) i_prbs_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .seed(seed), .user_pat(user_pat), .err_clr(err_clr),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_on(tx_on),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_on(rx_on),
    .rx_err(rx_err), .rx_lock(rx_lock), .rx_halted(rx_halted),
    .rx_err_cnt(rx_err_cnt)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference sequence: degree n polynomial, feedback from its two or four terms.
  function automatic logic [31:0] ref_word(inout logic [31:0] st, input int pat, input bit esc);
    int n;
    logic [31:0] m, w;
    logic f;
    if (pat == 7) return st;
    case (pat)
      0: n = 7;  1: n = 9;  2: n = 11; 3: n = 15;
      4: n = 23; 5: n = 31; default: n = 13;
    endcase
    m  = 32'((64'd1 << n) - 1);
    st = st & m;
    if (esc && st == 0) st = m;
    for (int i = 0; i < 32; i++) begin
      case (pat)
        0: f = st[6] ^ st[5];
        1: f = st[8] ^ st[4];
        2: f = st[10] ^ st[8];
        3: f = st[14] ^ st[13];
        4: f = st[22] ^ st[17];
        5: f = st[30] ^ st[27];
        default: f = st[12] ^ st[11] ^ st[1] ^ st[0];
      endcase
      st = ((st << 1) | {31'd0, f}) & m;
      w[31-i] = f;
    end
    return w;
  endfunction

  task automatic send_cmd(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rx_put(input logic [31:0] d);
    rx_valid = 1'b1;
    rx_data  = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic clear_cnt();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] st, st2, w;
    logic [CNT_W-1:0] c1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 tx_on", tx_on, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 tx_data", tx_data, 0);
    check("R1 rx_on", rx_on, 0);
    check("R1 flags", {rx_err, rx_lock, rx_halted}, 0);
    check("R1 count", rx_err_cnt, 0);

    // R3 every polynomial, distinct seeds
    for (int p = 0; p < 7; p++) begin
      seed = 32'hACE1_3579 + 32'(p * 7919);
      send_cmd(16'h0100 | 16'(p));
      check("R3 valid low after load", tx_valid, 0);
      st = seed;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        check($sformatf("R3 pat%0d word%0d", p, k), {tx_valid, tx_data}, {1'b1, ref_word(st, p, 0)});
      end
    end

    // R4 user word repeated, captured at load
    user_pat = 32'hA5C3_0F96;
    send_cmd(16'h0107);
    user_pat = 32'h1111_2222;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R4 user word", tx_data, 32'hA5C3_0F96);
    end

    // R5 zero escape versus stuck zero
    seed = 32'd0;
    send_cmd(16'h0125);
    st = 32'h7FFF_FFFF;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R5 escape to ones", tx_data, ref_word(st, 5, 0));
    end
    send_cmd(16'h0105);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R5 zero stays zero", tx_data, 0);
    end

    // R2 command with high bits set is ignored
    seed = 32'h0BAD_F00D;
    send_cmd(16'h0105);
    st = seed;
    @(negedge clk);
    check("R2 base word", tx_data, ref_word(st, 5, 0));
    seed = 32'h1234_5678;
    send_cmd(16'h0503);
    w = ref_word(st, 5, 0);
    w = ref_word(st, 5, 0);
    @(negedge clk);
    check("R2 reserved bits ignored", tx_data, ref_word(st, 5, 0));

    // R8 lock after 32 clean words
    seed = 32'h2468_ACE1;
    send_cmd(16'h0205);
    check("R12 rx on after load", rx_on, 1);
    st2 = seed;
    for (int k = 0; k < 32; k++) begin
      rx_put(ref_word(st2, 5, 0));
      if (k == 30) check("R8 no lock at 31", rx_lock, 0);
      if (k == 31) check("R8 lock at 32", rx_lock, 1);
    end
    check("R6 clean count", rx_err_cnt, 0);

    // R13 TX load leaves RX alone
    seed = 32'h0000_0055;
    send_cmd(16'h0100);
    for (int k = 0; k < 4; k++) begin
      rx_put(ref_word(st2, 5, 0));
      check("R13 rx still matches", {rx_err, rx_lock}, 2'b01);
    end

    // R6 popcount of mismatches
    rx_put(ref_word(st2, 5, 0) ^ 32'h0000_0111);
    check("R6 three bits", {rx_err, rx_err_cnt}, {1'b1, 12'd3});
    check("R8 lock drops", rx_lock, 0);
    rx_put(ref_word(st2, 5, 0));
    check("R6 clean word", {rx_err, rx_err_cnt}, {1'b0, 12'd3});
    rx_put(ref_word(st2, 5, 0) ^ 32'hFF00_0000);
    check("R6 eight bits", rx_err_cnt, 11);

    // R11 clear
    clear_cnt();
    check("R11 cleared", rx_err_cnt, 0);

    // R9 reseed follows a shifted stream
    seed = 32'h1357_9BDF;
    send_cmd(16'h0215);
    st2 = 32'h7654_3210;
    rx_put(ref_word(st2, 5, 0));
    check("R9 first mismatch", rx_err, 1);
    c1 = rx_err_cnt;
    for (int k = 0; k < 6; k++) begin
      rx_put(ref_word(st2, 5, 0));
      check("R9 following after reseed", {rx_err, rx_err_cnt}, {1'b0, c1});
    end
    send_cmd(16'h0205);
    st2 = 32'h7654_3210;
    rx_put(ref_word(st2, 5, 0));
    rx_put(ref_word(st2, 5, 0));
    check("R9 no reseed keeps failing", rx_err, 1);

    // R10 stop on error
    clear_cnt();
    seed = 32'h0F0F_1234;
    send_cmd(16'h0285);
    st2 = seed;
    for (int k = 0; k < 3; k++) rx_put(ref_word(st2, 5, 0));
    rx_put(ref_word(st2, 5, 0) ^ 32'h0000_0007);
    check("R10 halted", {rx_halted, rx_err_cnt}, {1'b1, 12'd3});
    rx_put(ref_word(st2, 5, 0) ^ 32'h0000_001F);
    check("R10 frozen", {rx_halted, rx_err, rx_err_cnt}, {2'b10, 12'd3});
    send_cmd(16'h0285);
    check("R10 reload releases", rx_halted, 0);
    st2 = seed;
    rx_put(ref_word(st2, 5, 0));
    check("R10 checks again", {rx_err, rx_err_cnt}, {1'b0, 12'd3});

    // R7 saturation with the narrowed counter
    clear_cnt();
    seed = 32'h5555_AAAA;
    send_cmd(16'h0205);
    st2 = seed;
    for (int k = 1; k <= 130; k++) begin
      rx_put(~ref_word(st2, 5, 0));
      if (k == 127) check("R7 before saturation", rx_err_cnt, 4064);
      if (k == 128) check("R7 saturates", rx_err_cnt, 4095);
    end
    check("R7 stays saturated", rx_err_cnt, 4095);

    // R12 disable codes
    send_cmd(16'h01FF);
    check("R12 tx off", {tx_on, tx_valid, tx_data}, 34'd0);
    check("R12 rx untouched", rx_on, 1);
    clear_cnt();
    send_cmd(16'h02FF);
    check("R12 rx off", {rx_on, rx_lock}, 2'b00);
    rx_put(32'hFFFF_0000);
    check("R12 off rx ignores data", {rx_err, rx_err_cnt}, {1'b0, 12'd0});
    seed = 32'h0000_0777;
    send_cmd(16'h0305);
    check("R12 both on", {tx_on, rx_on}, 2'b11);
    send_cmd(16'h03FF);
    check("R12 both off", {tx_on, rx_on, tx_valid}, 3'b000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule